// File: doc/BRIEF.md
# Indexed Register and Memory Access Window

This block sits at the front of a small register space. It gives a host two ways in. The first is direct access to any register address. The second is an indirect path: a 32-bit pointer register selects a target, and a four-byte data window then reaches that target. The pointer's top bit chooses the target space. When the bit is set, the target is video memory. When it is clear, the target is another register address.

Every host access carries a size of 1, 2 or 4 bytes. Data on the host side is right-justified. The block does all byte-lane placement for the word-wide register port. It also checks memory accesses against the memory size. An access that would run past the end of memory is dropped without any error.

Register targets complete in one cycle. Memory targets use a request/acknowledge handshake, and the host interface stays busy until the memory acknowledges.

Top module: `idx_window`

## Requirements
- R1: The pointer register sits at byte addresses 0..3 and resets to 0. A 4-byte read at address 0 returns the last value written there in full.
- R2: A 1- or 2-byte access at lane offset k (address bits [1:0]) deposits the low bytes of the write data into, or extracts them from, bits starting at 8*k of the 32-bit word. Lanes that would fall past byte 3 are discarded. A 4-byte access at offset 0 replaces the whole word.
- R3: An access to byte addresses 4..7 while pointer bit 31 is 0 goes to the register port at byte address (pointer + (address - 4)) modulo 2^RAW, with the same size and data.
- R4: An access to addresses 4..7 while pointer bit 31 is 1 goes to memory byte address pointer[30:0], whatever the window offset. The memory data is little-endian and right-justified.
- R5: A memory access is issued only when pointer[30:0] + size_bytes <= MEM_BYTES. Otherwise no memory request is raised, a read returns 0 and a write changes nothing.
- R6: When the indirect register target is address 0..7 itself, it is a plain register-port access. The pointer register is unchanged and there is no second indirection.
- R7: mem_req stays high, with stable address and direction, until mem_ack is sampled high. out_done pulses in the cycle after the acknowledge. host_ready is low while the request is pending, and requests offered while busy are ignored.
- R8: in_size encoding is 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Read data is zero above the access size, and out_rdata is 0 for writes.
- R9: Any other address goes straight to the register port, with no memory request. out_done follows one cycle after acceptance.
- R10: After reset, host_ready is 1, out_done is 0 and no port request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Host access request, taken when host_ready is 1 |
| in_we | input | 1 | 1 = write, 0 = read |
| in_addr | input | RAW | Host byte address |
| in_size | input | 2 | Access size code |
| in_wdata | input | 32 | Right-justified write data |
| host_ready | output | 1 | Block idle, can take a request |
| out_done | output | 1 | One-cycle completion pulse |
| out_rdata | output | 32 | Right-justified read data, valid with out_done |
| reg_en | output | 1 | Register port access strobe |
| reg_we | output | 1 | Register port write |
| reg_addr | output | RAW | Word-aligned register byte address |
| reg_be | output | 4 | Register byte enables |
| reg_wdata | output | 32 | Lane-placed register write data |
| reg_rdata | input | 32 | Register word read data |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory write |
| mem_addr | output | MAW | Memory byte address |
| mem_size | output | 2 | Memory access size code |
| mem_wdata | output | 32 | Right-justified memory write data |
| mem_rdata | input | 32 | Right-justified little-endian memory read data |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The hardest case to reach is the acknowledge window of a memory access. Here a second host request arrives while the first is still waiting on the memory, so the drop has to be seen through later state rather than at once. The bench holds the memory acknowledge off for several cycles. During that wait it offers a pointer write, then reads the pointer back afterwards. The memory bound is probed on both sides of the limit, with pointers at the last valid start address for each size and one past it. Memory contents are then read back to show that dropped writes left nothing behind.

// File: rtl/idx_win_pkg.sv
`timescale 1ns/1ps
package idx_win_pkg;

    typedef enum logic [1:0] {
        K_INDEX = 2'd0,
        K_REG   = 2'd1,
        K_MEM   = 2'd2,
        K_DROP  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_IDX  = 3'd1,
        S_REG  = 3'd2,
        S_MEM  = 3'd3,
        S_DROP = 3'd4
    } state_e;

    typedef struct packed {
        kind_e       kind;
        logic        we;
        logic [1:0]  size;
        logic [31:0] wdata;
    } op_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] s);
        case (s)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] s);
        case (s)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [3:0] lane_enables(input logic [1:0] s, input logic [1:0] off);
        logic [6:0] m;
        case (s)
            2'd0:    m = 7'b000_0001;
            2'd1:    m = 7'b000_0011;
            default: m = 7'b000_1111;
        endcase
        m = m << off;
        return m[3:0];
    endfunction

    function automatic logic [31:0] be_bits(input logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = {8{be[i]}};
        return r;
    endfunction

    function automatic logic [31:0] lane_place(input logic [31:0] d, input logic [1:0] off);
        return d << {off, 3'b000};
    endfunction

    function automatic logic [31:0] lane_pull(input logic [31:0] w, input logic [1:0] s,
                                              input logic [1:0] off);
        return (w >> {off, 3'b000}) & size_mask(s);
    endfunction

endpackage

// File: rtl/idx_win_decode.sv
`timescale 1ns/1ps
module idx_win_decode
    import idx_win_pkg::*;
#(
    parameter int RAW       = 14,
    parameter int MAW       = 12,
    parameter int MEM_BYTES = 4096,
    parameter int IDX_ADDR  = 0,
    parameter int WIN_ADDR  = 4
) (
    input  logic            in_we,
    input  logic [RAW-1:0]  in_addr,
    input  logic [1:0]      in_size,
    input  logic [31:0]     in_wdata,
    input  logic [31:0]     index_q,
    output op_t             op,
    output logic [RAW-1:0]  raddr,
    output logic [MAW-1:0]  maddr
);
    localparam logic [RAW-1:0] IDX_A = RAW'(IDX_ADDR);
    localparam logic [RAW-1:0] WIN_A = RAW'(WIN_ADDR);
    localparam logic [32:0]    MEM_LIM = 33'(MEM_BYTES);

    logic        idx_hit, win_hit, in_bounds;
    logic [32:0] end_addr;

    assign idx_hit   = (in_addr[RAW-1:2] == IDX_A[RAW-1:2]);
    assign win_hit   = (in_addr[RAW-1:2] == WIN_A[RAW-1:2]);
    assign end_addr  = {2'b00, index_q[30:0]} + 33'(size_bytes(in_size));
    assign in_bounds = (end_addr <= MEM_LIM);

    always_comb begin
        op.we    = in_we;
        op.size  = in_size;
        op.wdata = in_wdata;
        op.kind  = K_REG;
        raddr    = in_addr;
        maddr    = index_q[MAW-1:0];
        if (idx_hit) begin
            op.kind = K_INDEX;
        end else if (win_hit) begin
            if (index_q[31]) begin
                op.kind = in_bounds ? K_MEM : K_DROP;
            end else begin
                raddr = index_q[RAW-1:0] + RAW'(in_addr[1:0]);
            end
        end
    end
endmodule

// File: rtl/idx_lane_unit.sv
`timescale 1ns/1ps
module idx_lane_unit
    import idx_win_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [1:0]  off,
    input  logic [31:0] wdata,
    input  logic [31:0] reg_rdata,
    input  logic [31:0] index_q,
    output logic [3:0]  be,
    output logic [31:0] wdata_lanes,
    output logic [31:0] index_next,
    output logic [31:0] reg_pull,
    output logic [31:0] index_pull
);
    logic [31:0] bits;

    assign be          = lane_enables(size, off);
    assign bits        = be_bits(be);
    assign wdata_lanes = lane_place(wdata, off);
    assign index_next  = (index_q & ~bits) | (wdata_lanes & bits);
    assign reg_pull    = lane_pull(reg_rdata, size, off);
    assign index_pull  = lane_pull(index_q, size, off);
endmodule

// File: rtl/idx_mem_hs.sv
`timescale 1ns/1ps
module idx_mem_hs (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mem_ack,
    output logic mem_req,
    output logic complete
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)                  pend_q <= 1'b0;
        else if (pend_q && mem_ack) pend_q <= 1'b0;
        else if (start)           pend_q <= 1'b1;
    end

    assign mem_req  = pend_q;
    assign complete = pend_q && mem_ack;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    // R7
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !start) |=> !mem_req);
endmodule

// File: rtl/idx_window.sv
`timescale 1ns/1ps
module idx_window
    import idx_win_pkg::*;
#(
    parameter int RAW       = 14,
    parameter int MEM_BYTES = 4096,
    parameter int IDX_ADDR  = 0,
    parameter int WIN_ADDR  = 4,
    localparam int MAW      = $clog2(MEM_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_req,
    input  logic            in_we,
    input  logic [RAW-1:0]  in_addr,
    input  logic [1:0]      in_size,
    input  logic [31:0]     in_wdata,
    output logic            host_ready,
    output logic            out_done,
    output logic [31:0]     out_rdata,
    output logic            reg_en,
    output logic            reg_we,
    output logic [RAW-1:0]  reg_addr,
    output logic [3:0]      reg_be,
    output logic [31:0]     reg_wdata,
    input  logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [MAW-1:0]  mem_addr,
    output logic [1:0]      mem_size,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack
);
    state_e         state;
    op_t            op_d, op_q;
    logic [RAW-1:0] raddr_d, raddr_q;
    logic [MAW-1:0] maddr_d, maddr_q;
    logic [31:0]    index_q, index_next, reg_pull, index_pull;
    logic           accept, mem_start, mem_done, done_q;
    logic [31:0]    rdata_q;

    idx_win_decode #(
        .RAW(RAW), .MAW(MAW), .MEM_BYTES(MEM_BYTES),
        .IDX_ADDR(IDX_ADDR), .WIN_ADDR(WIN_ADDR)
    ) u_dec (
        .in_we(in_we), .in_addr(in_addr), .in_size(in_size), .in_wdata(in_wdata),
        .index_q(index_q), .op(op_d), .raddr(raddr_d), .maddr(maddr_d)
    );

    idx_lane_unit u_lane (
        .size(op_q.size), .off(raddr_q[1:0]), .wdata(op_q.wdata),
        .reg_rdata(reg_rdata), .index_q(index_q), .be(reg_be),
        .wdata_lanes(reg_wdata), .index_next(index_next),
        .reg_pull(reg_pull), .index_pull(index_pull)
    );

    assign accept    = in_req && (state == S_IDLE);
    assign mem_start = accept && (op_d.kind == K_MEM);

    idx_mem_hs u_hs (
        .clk(clk), .rst(rst), .start(mem_start), .mem_ack(mem_ack),
        .mem_req(mem_req), .complete(mem_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            op_q    <= '0;
            raddr_q <= '0;
            maddr_q <= '0;
            index_q <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    op_q    <= op_d;
                    raddr_q <= raddr_d;
                    maddr_q <= maddr_d;
                    case (op_d.kind)
                        K_INDEX: state <= S_IDX;
                        K_REG:   state <= S_REG;
                        K_MEM:   state <= S_MEM;
                        default: state <= S_DROP;
                    endcase
                end
                S_IDX: begin
                    if (op_q.we) index_q <= index_next;
                    rdata_q <= op_q.we ? 32'h0 : index_pull;
                    done_q  <= 1'b1;
                    state   <= S_IDLE;
                end
                S_REG: begin
                    rdata_q <= op_q.we ? 32'h0 : reg_pull;
                    done_q  <= 1'b1;
                    state   <= S_IDLE;
                end
                S_MEM: if (mem_done) begin
                    rdata_q <= op_q.we ? 32'h0 : (mem_rdata & size_mask(op_q.size));
                    done_q  <= 1'b1;
                    state   <= S_IDLE;
                end
                default: begin
                    rdata_q <= 32'h0;
                    done_q  <= 1'b1;
                    state   <= S_IDLE;
                end
            endcase
        end
    end

    assign host_ready = (state == S_IDLE);
    assign out_done   = done_q;
    assign out_rdata  = rdata_q;
    assign reg_en     = (state == S_REG);
    assign reg_we     = op_q.we;
    assign reg_addr   = {raddr_q[RAW-1:2], 2'b00};
    assign mem_we     = op_q.we;
    assign mem_addr   = maddr_q;
    assign mem_size   = op_q.size;
    assign mem_wdata  = op_q.wdata & size_mask(op_q.size);

    // R7
    mem_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !host_ready);

    // R7
    ack_done_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> out_done);

    // R5
    mem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((33'(mem_addr) + 33'(size_bytes(mem_size))) <= 33'(MEM_BYTES)));

    // R9
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && reg_en));

    // R2
    lane_live_chk: assert property (@(posedge clk) disable iff (rst)
        reg_en |-> (reg_be != 4'b0000));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);
endmodule

// File: tb/idx_window_tb.sv
`timescale 1ns/1ps
module idx_window_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RAW        = 14;
    localparam int MEMB       = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            in_req = 1'b0, in_we = 1'b0;
    logic [RAW-1:0]  in_addr = '0;
    logic [1:0]      in_size = 2'd0;
    logic [31:0]     in_wdata = '0;
    logic            host_ready, out_done;
    logic [31:0]     out_rdata;
    logic            reg_en, reg_we;
    logic [RAW-1:0]  reg_addr;
    logic [3:0]      reg_be;
    logic [31:0]     reg_wdata, reg_rdata;
    logic            mem_req, mem_we, mem_ack;
    logic [11:0]     mem_addr;
    logic [1:0]      mem_size;
    logic [31:0]     mem_wdata, mem_rdata;

    idx_window #(.RAW(RAW), .MEM_BYTES(MEMB)) u_dut (
        .clk(clk), .rst(rst), .in_req(in_req), .in_we(in_we), .in_addr(in_addr),
        .in_size(in_size), .in_wdata(in_wdata), .host_ready(host_ready),
        .out_done(out_done), .out_rdata(out_rdata), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // register file model: word array, byte enables
    logic [31:0] rf [0:63];
    int          reg_cnt;
    logic [RAW-1:0] last_reg_addr;
    assign reg_rdata = rf[reg_addr[7:2]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) rf[i] <= 32'h0;
            reg_cnt <= 0;
            last_reg_addr <= '0;
        end else if (reg_en) begin
            reg_cnt <= reg_cnt + 1;
            last_reg_addr <= reg_addr;
            if (reg_we)
                for (int b = 0; b < 4; b++)
                    if (reg_be[b]) rf[reg_addr[7:2]][8*b +: 8] <= reg_wdata[8*b +: 8];
        end
    end

    // memory model: byte array, ack after a fixed wait
    logic [7:0] mem [0:MEMB-1];
    logic [2:0] wait_cnt;
    int         mem_cnt;
    assign mem_rdata = {mem[mem_addr + 12'd3], mem[mem_addr + 12'd2],
                        mem[mem_addr + 12'd1], mem[mem_addr]};
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEMB; i++) mem[i] <= 8'h0;
            mem_ack <= 1'b0; wait_cnt <= '0; mem_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; wait_cnt <= '0;
            mem_cnt <= mem_cnt + 1;
            if (mem_we)
                for (int b = 0; b < 4; b++)
                    if (b < ((mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4))
                        mem[mem_addr + 12'(b)] <= mem_wdata[8*b +: 8];
        end else if (mem_req) begin
            if (wait_cnt == 3'd2) mem_ack <= 1'b1;
            else wait_cnt <= wait_cnt + 3'd1;
        end
    end

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [RAW-1:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        in_req = 1'b1; in_we = we; in_addr = a; in_size = sz; in_wdata = wd;
        @(posedge clk);
        #1 in_req = 1'b0;
        lat = 0; rd = 32'hX;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (out_done) begin rd = out_rdata; break; end
        end
    endtask

    task automatic wr(input logic [RAW-1:0] a, input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] r; int l;
        acc(1'b1, a, sz, d, r, l);
    endtask

    task automatic rd(input logic [RAW-1:0] a, input logic [1:0] sz, output logic [31:0] v);
        int l;
        acc(1'b0, a, sz, 32'h0, v, l);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        check("R10 ready", {31'b0, host_ready}, 32'd1);
        check("R10 done", {31'b0, out_done}, 32'd0);
        check("R10 req", {30'b0, mem_req, reg_en}, 32'd0);
        rd(14'h0, 2'd2, v);
        check("R1 index reset", v, 32'h0);
    endtask

    task automatic t_index;
        logic [31:0] v;
        wr(14'h0, 2'd2, 32'h8000_1234);
        rd(14'h0, 2'd2, v);
        check("R1 index full", v, 32'h8000_1234);
        wr(14'h0, 2'd2, 32'h1122_3344);
        wr(14'h2, 2'd0, 32'hFFFF_FFAB);
        rd(14'h0, 2'd2, v);
        check("R2 index byte deposit", v, 32'h11AB_3344);
        rd(14'h1, 2'd1, v);
        check("R2 index half extract", v, 32'h0000_AB33);
    endtask

    task automatic t_direct;
        logic [31:0] v; logic [31:0] r; int l, m0;
        m0 = mem_cnt;
        wr(14'h40, 2'd2, 32'h1122_3344);
        check("R9 direct word", rf[16], 32'h1122_3344);
        wr(14'h43, 2'd0, 32'h0000_0099);
        check("R2 direct byte", rf[16], 32'h9922_3344);
        acc(1'b0, 14'h41, 2'd1, 32'h0, r, l);
        check("R2 direct half read", r, 32'h0000_2233);
        check("R9 direct latency", l, 1);
        wr(14'h43, 2'd2, 32'hAABB_CCDD);
        check("R2 lane clip", rf[16], 32'hDD22_3344);
        rd(14'h40, 2'd0, v);
        check("R8 byte zero-extend", v, 32'h0000_0044);
        acc(1'b1, 14'h40, 2'd0, 32'h0000_0044, r, l);
        check("R8 write rdata", r, 32'h0);
        check("R9 no memory traffic", mem_cnt, m0);
    endtask

    task automatic t_win_reg;
        logic [31:0] v;
        wr(14'h0, 2'd2, 32'h0000_0080);
        wr(14'h4, 2'd2, 32'h0102_0304);
        check("R3 window word", rf[32], 32'h0102_0304);
        wr(14'h6, 2'd0, 32'h0000_005A);
        check("R3 window offset byte", rf[32], 32'h015A_0304);
        rd(14'h5, 2'd1, v);
        check("R3 window half read", v, 32'h0000_5A03);
        check("R3 target address", {18'b0, last_reg_addr}, 32'h80);
    endtask

    task automatic t_win_mem;
        logic [31:0] v;
        wr(14'h0, 2'd2, 32'h8000_0010);
        wr(14'h4, 2'd2, 32'hDEAD_BEEF);
        check("R4 mem LE byte0", {24'b0, mem[16]}, 32'hEF);
        check("R4 mem LE byte3", {24'b0, mem[19]}, 32'hDE);
        wr(14'h7, 2'd0, 32'h0000_0077);
        check("R4 offset ignored", {24'b0, mem[16]}, 32'h77);
        rd(14'h6, 2'd1, v);
        check("R4 half read", v, 32'h0000_BE77);
        rd(14'h4, 2'd3, v);
        check("R8 size code 3", v, 32'hDEAD_BE77);
    endtask

    task automatic t_bounds;
        logic [31:0] v; int m0;
        wr(14'h0, 2'd2, 32'h8000_0FFC);
        wr(14'h4, 2'd2, 32'h0102_0304);
        rd(14'h4, 2'd2, v);
        check("R5 last word ok", v, 32'h0102_0304);
        wr(14'h0, 2'd2, 32'h8000_0FFD);
        m0 = mem_cnt;
        rd(14'h4, 2'd2, v);
        check("R5 over read zero", v, 32'h0);
        check("R5 over read no request", mem_cnt, m0);
        wr(14'h0, 2'd2, 32'h8000_0FFF);
        wr(14'h4, 2'd2, 32'hFFFF_FFFF);
        check("R5 over write no request", mem_cnt, m0);
        wr(14'h4, 2'd0, 32'h0000_00AA);
        check("R5 last byte ok", {24'b0, mem[4095]}, 32'hAA);
        wr(14'h0, 2'd2, 32'h8000_0FFE);
        wr(14'h4, 2'd1, 32'h0000_5566);
        wr(14'h0, 2'd2, 32'h8000_0FFC);
        rd(14'h4, 2'd2, v);
        check("R5 last half ok", v, 32'h5566_0304);
        wr(14'h0, 2'd2, 32'h8000_1000);
        m0 = mem_cnt;
        rd(14'h4, 2'd0, v);
        check("R5 past end zero", v, 32'h0);
        check("R5 past end no request", mem_cnt, m0);
    endtask

    task automatic t_self;
        logic [31:0] v;
        wr(14'h0, 2'd2, 32'h0000_0004);
        wr(14'h4, 2'd2, 32'hCAFE_0001);
        check("R6 window self target", rf[1], 32'hCAFE_0001);
        rd(14'h0, 2'd2, v);
        check("R6 index kept", v, 32'h0000_0004);
        wr(14'h0, 2'd2, 32'h0000_0000);
        wr(14'h4, 2'd2, 32'h0BAD_F00D);
        check("R6 index-addr target", rf[0], 32'h0BAD_F00D);
        rd(14'h0, 2'd2, v);
        check("R6 index still zero", v, 32'h0);
    endtask

    task automatic t_handshake;
        logic [31:0] v; int lat;
        logic saw_busy;
        wr(14'h0, 2'd2, 32'h8000_0010);
        @(negedge clk);
        in_req = 1'b1; in_we = 1'b0; in_addr = 14'h4; in_size = 2'd2; in_wdata = '0;
        @(posedge clk);
        #1 in_req = 1'b0;
        @(negedge clk);
        saw_busy = mem_req && !host_ready;
        in_req = 1'b1; in_we = 1'b1; in_addr = 14'h0; in_size = 2'd2; in_wdata = 32'h1234_5678;
        @(posedge clk);
        #1 in_req = 1'b0;
        lat = 1; v = 32'h0;
        for (int k = 0; k < 50; k++) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (out_done) begin v = out_rdata; break; end
        end
        check("R7 busy while pending", {31'b0, saw_busy}, 32'd1);
        check("R7 completion latency", lat, 4);
        check("R7 read data", v, 32'hDEAD_BE77);
        rd(14'h0, 2'd2, v);
        check("R7 busy request ignored", v, 32'h8000_0010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_index();
        t_direct();
        t_win_reg();
        t_win_mem();
        t_bounds();
        t_self();
        t_handshake();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule